// File: doc/BRIEF.md
# USB Host Controller Command, Status and Interrupt-Enable Registers

This block holds the software-visible control state of a simple full/low-speed USB host controller. It has a 16-bit command register, a status register and an interrupt-enable register, all reached through a small word-addressed register bus. The command register starts and stops the schedule and carries the reset, suspend, resume, debug, configured and packet-size controls. Its run bit and its packet-size selection are also driven out to the transfer engine.

The transfer engine reports what happened on the bus as single-cycle pulses. Each pulse sets a sticky status flag, and software clears a flag by writing a one to its position. A halted flag follows the run bit with a one-cycle lag. One level-sensitive interrupt line is raised while a latched event is pending and its class is enabled.

A write that sets the controller-reset bit shows that bit for one cycle. After that cycle the bit clears itself and every register returns to its reset value.

Top module: `hostCtlRegs`

## Requirements
- R1: After reset the command register reads 0x0000, the status register reads 0x0020 (halted only), the enable register reads 0x0000, `irqOut` and `schedRun` are 0, and `maxPktLen` is 32.
- R2: Command register bits 7..0 are written as run/stop (bit 0), controller reset (bit 1), global reset (bit 2), global suspend (bit 3), force resume (bit 4), debug (bit 5), configured (bit 6) and packet size (bit 7). Bits 15..8 read as zero. `schedRun` follows bit 0.
- R3: `maxPktLen` is 32 while command bit 7 is 0 and 64 while it is 1.
- R4: Enable register bits are timeout/CRC (bit 0), resume (bit 1), on-complete (bit 2) and short packet (bit 3). Written upper bits are dropped and read as zero.
- R5: `evtPulse` bit 0 (transfer complete) and bit 1 (short packet) set status bit 0. Bit 2 (error) sets status bit 1, bit 3 (resume received) sets status bit 2, bit 4 (bus error) sets status bit 3, and bit 5 (process error) sets status bit 4.
- R6: Status bits 4..0 stay set until software writes 1 to that position. Writing 0 leaves a bit unchanged.
- R7: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R8: Status bit 5 (halted) becomes 1 at the second clock edge after run/stop is written to 0. It becomes 0 at the same edge that writes run/stop to 1.
- R9: `irqOut` = (status0 AND (enable2 OR enable3)) OR (status1 AND enable0) OR (status2 AND enable1).
- R10: A command write with bit 1 set reads back with bit 1 high for one cycle. At the next edge all registers take their R1 values, and event pulses in that cycle are discarded.
- R11: Read address 0 returns command, 1 returns status, 2 returns enable, and 3 returns zero. `busRdData` follows `busAddr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe for the word at busAddr |
| busAddr | input | 2 | Word address: 0 command, 1 status, 2 enable |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for busAddr |
| evtPulse | input | 6 | Single-cycle event pulses from the transfer engine |
| irqOut | output | 1 | Level interrupt request |
| schedRun | output | 1 | Schedule run bit |
| maxPktLen | output | 7 | Selected maximum packet length in bytes |

## Verification
If a sticky flag is lost or set by mistake, the status word is wrong on the read right after the edge. If the interrupt line still has its enable, `irqOut` is wrong in that same cycle. If the halted flag is tracked wrongly, the error shows only when status is read in the exact cycles around a run/stop change, so reads are placed both at the write edge and one edge later. A controller reset that fails to clear itself leaves command bit 1 set, or leaves stale enable and status contents, on the read taken two edges after the write.

// File: rtl/hostCtlPkg.sv
package hostCtlPkg;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 2;
  localparam int CMD_BITS = 8;
  localparam int STS_BITS = 6;
  localparam int IEN_BITS = 4;
  localparam int EVT_BITS = 6;

  localparam logic [ADDR_W-1:0] ADDR_CMD = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STS = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_IEN = 2'd2;

  localparam int CMD_RUN   = 0;
  localparam int CMD_HCRST = 1;
  localparam int CMD_MAXP  = 7;
  localparam int STS_HALT  = 5;

  typedef struct packed {
    logic cmdWr;
    logic stsWr;
    logic ienWr;
    logic hcRst;
  } regStrobe_t;
endpackage

// File: rtl/hostCtlCtrl.sv
module hostCtlCtrl
  import hostCtlPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output regStrobe_t        strb
);
  logic rstPend;

  always_ff @(posedge clk) begin
    if (!rstN)        rstPend <= 1'b0;
    else if (rstPend) rstPend <= 1'b0;
    else              rstPend <= busWrEn && (busAddr == ADDR_CMD) && busWrData[CMD_HCRST];
  end

  always_comb begin
    strb.cmdWr = busWrEn && (busAddr == ADDR_CMD);
    strb.stsWr = busWrEn && (busAddr == ADDR_STS);
    strb.ienWr = busWrEn && (busAddr == ADDR_IEN);
    strb.hcRst = rstPend;
  end

  // R10
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstPend |=> !rstPend);
endmodule

// File: rtl/hostCtlData.sv
module hostCtlData
  import hostCtlPkg::*;
#(
  parameter int PKT_SMALL = 32,
  parameter int PKT_LARGE = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strb,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  input  logic [EVT_BITS-1:0] evtPulse,
  output logic [DATA_W-1:0]   busRdData,
  output logic                irqOut,
  output logic                schedRun,
  output logic [6:0]          maxPktLen
);
  localparam int FLAG_BITS = STS_BITS - 1;

  logic [CMD_BITS-1:0]  cmdQ;
  logic [STS_BITS-1:0]  stsQ;
  logic [IEN_BITS-1:0]  ienQ;
  logic [FLAG_BITS-1:0] setEvt;
  logic [DATA_W-1:0]    cmdRd, stsRd, ienRd;

  always_comb begin
    setEvt[0] = evtPulse[0] | evtPulse[1];
    setEvt[1] = evtPulse[2];
    setEvt[2] = evtPulse[3];
    setEvt[3] = evtPulse[4];
    setEvt[4] = evtPulse[5];
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.hcRst) cmdQ <= '0;
    else if (strb.cmdWr)     cmdQ <= busWrData[CMD_BITS-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.hcRst) ienQ <= '0;
    else if (strb.ienWr)     ienQ <= busWrData[IEN_BITS-1:0];
  end

  for (genvar i = 0; i < FLAG_BITS; i++) begin : gFlag
    always_ff @(posedge clk) begin
      if (!rstN || strb.hcRst)                stsQ[i] <= 1'b0;
      else if (setEvt[i])                     stsQ[i] <= 1'b1;
      else if (strb.stsWr && busWrData[i])    stsQ[i] <= 1'b0;
    end

    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stsQ[i] && !strb.hcRst && !(strb.stsWr && busWrData[i])) |=> stsQ[i]);
    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      (setEvt[i] && !strb.hcRst) |=> stsQ[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.hcRst)                     stsQ[STS_HALT] <= 1'b1;
    else if (strb.cmdWr && busWrData[CMD_RUN])   stsQ[STS_HALT] <= 1'b0;
    else if (!cmdQ[CMD_RUN])                     stsQ[STS_HALT] <= 1'b1;
  end

  // R8
  halt_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!schedRun && !(strb.cmdWr && busWrData[CMD_RUN])) |=> stsQ[STS_HALT]);
  // R10
  hc_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.hcRst |=> (cmdQ == '0 && ienQ == '0 && !irqOut));

  assign cmdRd = {{(DATA_W-CMD_BITS){1'b0}}, cmdQ};
  assign stsRd = {{(DATA_W-STS_BITS){1'b0}}, stsQ};
  assign ienRd = {{(DATA_W-IEN_BITS){1'b0}}, ienQ};

  always_comb begin
    case (busAddr)
      ADDR_CMD: busRdData = cmdRd;
      ADDR_STS: busRdData = stsRd;
      ADDR_IEN: busRdData = ienRd;
      default:  busRdData = '0;
    endcase
  end

  assign irqOut    = (stsQ[0] & (ienQ[2] | ienQ[3])) | (stsQ[1] & ienQ[0]) | (stsQ[2] & ienQ[1]);
  assign schedRun  = cmdQ[CMD_RUN];
  assign maxPktLen = cmdQ[CMD_MAXP] ? 7'(PKT_LARGE) : 7'(PKT_SMALL);

  // R9
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stsQ[2:0] == 3'b000) |-> !irqOut);

  // R2
  always_comb begin
    if (rstN) begin
      reserved_zero_chk: assert (busRdData[DATA_W-1:CMD_BITS] == '0);
    end
  end
endmodule

// File: rtl/hostCtlRegs.sv
module hostCtlRegs
  import hostCtlPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic [1:0]  busAddr,
  input  logic [15:0] busWrData,
  output logic [15:0] busRdData,
  input  logic [5:0]  evtPulse,
  output logic        irqOut,
  output logic        schedRun,
  output logic [6:0]  maxPktLen
);
  regStrobe_t strb;

  hostCtlCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .strb      (strb)
  );

  hostCtlData #(.PKT_SMALL(32), .PKT_LARGE(64)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .evtPulse  (evtPulse),
    .busRdData (busRdData),
    .irqOut    (irqOut),
    .schedRun  (schedRun),
    .maxPktLen (maxPktLen)
  );
endmodule

// File: tb/sim_hostCtlRegs.sv
`timescale 1ns/1ps
module sim_hostCtlRegs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [15:0] busWrData = 16'h0;
  logic [15:0] busRdData;
  logic [5:0]  evtPulse = 6'h0;
  logic        irqOut, schedRun;
  logic [6:0]  maxPktLen;
  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  hostCtlRegs u0 (.*);

  // {wr, wAddr, wData, evt, rAddr, expRd, expIrq}
  localparam int NVEC = 21;
  localparam logic [43:0] VEC [NVEC] = '{
    {1'b0,2'd0,16'h0000,6'h00,2'd1,16'h0020,1'b0},
    {1'b1,2'd2,16'h0004,6'h00,2'd2,16'h0004,1'b0},
    {1'b1,2'd2,16'hFFFF,6'h00,2'd2,16'h000F,1'b0},
    {1'b0,2'd0,16'h0000,6'h01,2'd1,16'h0021,1'b1},
    {1'b1,2'd2,16'h0008,6'h00,2'd1,16'h0021,1'b1},
    {1'b1,2'd2,16'h0000,6'h00,2'd1,16'h0021,1'b0},
    {1'b1,2'd1,16'h0000,6'h00,2'd1,16'h0021,1'b0},
    {1'b1,2'd1,16'h0001,6'h00,2'd1,16'h0020,1'b0},
    {1'b0,2'd0,16'h0000,6'h34,2'd1,16'h003A,1'b0},
    {1'b1,2'd2,16'h0001,6'h00,2'd1,16'h003A,1'b1},
    {1'b1,2'd1,16'h0008,6'h00,2'd1,16'h0032,1'b1},
    {1'b1,2'd1,16'h0012,6'h00,2'd1,16'h0020,1'b0},
    {1'b0,2'd0,16'h0000,6'h08,2'd1,16'h0024,1'b0},
    {1'b1,2'd2,16'h0002,6'h00,2'd1,16'h0024,1'b1},
    {1'b1,2'd1,16'h0004,6'h00,2'd1,16'h0020,1'b0},
    {1'b1,2'd0,16'hFFC1,6'h00,2'd0,16'h00C1,1'b0},
    {1'b0,2'd0,16'h0000,6'h00,2'd1,16'h0000,1'b0},
    {1'b1,2'd0,16'h0080,6'h00,2'd0,16'h0080,1'b0},
    {1'b0,2'd0,16'h0000,6'h00,2'd1,16'h0020,1'b0},
    {1'b1,2'd2,16'h0008,6'h02,2'd1,16'h0021,1'b1},
    {1'b1,2'd1,16'h0001,6'h00,2'd1,16'h0020,1'b0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [1:0] wa, input logic [15:0] wd,
                      input logic [5:0] ev, input logic [1:0] ra);
    @(negedge clk);
    busWrEn = wr; busAddr = wa; busWrData = wd; evtPulse = ev;
    @(posedge clk);
    #1;
    busWrEn = 1'b0; evtPulse = '0; busAddr = ra;
    #1;
  endtask

  task automatic readAt(input logic [1:0] ra);
    busAddr = ra;
    #1;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1 reset values
    readAt(2'd0); check("R1 cmd", busRdData, 16'h0000);
    readAt(2'd1); check("R1 sts", busRdData, 16'h0020);
    readAt(2'd2); check("R1 ien", busRdData, 16'h0000);
    check("R1 irq", {15'd0, irqOut}, 16'h0);
    check("R1 run", {15'd0, schedRun}, 16'h0);
    check("R3 maxPkt reset", {9'd0, maxPktLen}, 16'd32);
    readAt(2'd3); check("R11 addr3", busRdData, 16'h0000);

    // table: R4 R5 R6 R7 R9 R2 R8
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][43], VEC[i][42:41], VEC[i][40:25], VEC[i][24:19], VEC[i][18:17]);
      check($sformatf("R5/R6/R9 vec%0d rd", i), busRdData, VEC[i][16:1]);
      check($sformatf("R9 vec%0d irq", i), {15'd0, irqOut}, {15'd0, VEC[i][0]});
    end
    check("R3 maxPkt 64", {9'd0, maxPktLen}, 16'd64);

    // R8 halted lag
    step(1'b1, 2'd0, 16'h0001, 6'h00, 2'd1);
    check("R8 halt clears on run", busRdData, 16'h0000);
    check("R2 schedRun", {15'd0, schedRun}, 16'h1);
    step(1'b1, 2'd0, 16'h0000, 6'h00, 2'd1);
    check("R8 halt lag", busRdData, 16'h0000);
    step(1'b0, 2'd0, 16'h0000, 6'h00, 2'd1);
    check("R8 halt set", busRdData, 16'h0020);

    // R7 set beats clear
    step(1'b1, 2'd2, 16'h0004, 6'h00, 2'd1);
    step(1'b1, 2'd1, 16'h0001, 6'h01, 2'd1);
    check("R7 set wins", busRdData, 16'h0021);
    check("R7 irq", {15'd0, irqOut}, 16'h1);

    // R10 controller reset
    step(1'b1, 2'd0, 16'h0083, 6'h00, 2'd0);
    check("R10 bit1 visible", busRdData, 16'h0083);
    check("R3 maxPkt", {9'd0, maxPktLen}, 16'd64);
    step(1'b0, 2'd0, 16'h0000, 6'h01, 2'd0);
    check("R10 cmd cleared", busRdData, 16'h0000);
    readAt(2'd1); check("R10 sts reset evt dropped", busRdData, 16'h0020);
    readAt(2'd2); check("R10 ien reset", busRdData, 16'h0000);
    check("R10 irq", {15'd0, irqOut}, 16'h0);
    check("R10 maxPkt", {9'd0, maxPktLen}, 16'd32);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule